// File: doc/BRIEF.md
# Divided-Clock Synchronized Register Commit with Amplitude Scaling

This block runs on a fast system clock and produces a synchronization clock at one quarter of that rate, which it exports so that outside logic can time itself against it. Control values are written through a simple parallel port into a bank of buffer registers. Writing a buffer has no effect on behaviour until an external update strobe is seen rising. The strobe is sampled only at the rising edge of the synchronization clock and is edge detected there. Each low-to-high transition then moves the whole buffer bank into the active bank in one system cycle, so the delay from the system clock to the commit is fixed.

The two profile-select pins and the keying pin are also sampled on the synchronization clock before they reach the core. A data path passes samples through a registered stage. When the committed control word selects the external keying mode, the committed 14-bit scale register sets the gain of that stage.

Top module: `sync_update_core`

## Requirements
- R1: After reset the internal divider is at phase 0. syncClkOut is high in phases 0 and 1 and low in phases 2 and 3. The phase advances by one on every system clock edge, so syncClkOut has a period of four system cycles.
- R2: While syncClkDisable is high, syncClkOut stays low in every phase. Clearing syncClkDisable brings the R1 waveform back at once.
- R3: updateStrobe is sampled only at the system clock edge that ends phase 3, which is the rising edge of the synchronization clock. A first high sample after a low one causes a commit: activeBus takes the buffer values at the next system clock edge and is still unchanged in the phase-0 cycle.
- R4: A strobe that stays high commits only once. Another commit requires the strobe to be sampled low at least once.
- R5: A commit copies every buffer register into its active register at the same edge.
- R6: When a buffer register is written several times between two commits, only the last value is committed.
- R7: Buffer writes without an update edge leave activeBus unchanged.
- R8: Reset clears every active register to zero. A strobe that is already high when reset is released does not commit until it has been sampled low and then high.
- R9: profileSync and keySync take the values of profileIn and keyIn sampled at the rising edge of the synchronization clock, and hold them for the other three phases.
- R10: Register 0 is the control word and register 1 holds the scale in bits [13:0]. When control bit 25 is 1 and bit 24 is 0, dataOut equals (dataIn × scale) >> 14 one system cycle after dataIn is applied.
- R11: For the control bit pairs 00, 01 and 11 on bits 25:24, dataOut equals dataIn one system cycle later.
- R12: When wrEn is high at a system clock edge, buffer register wrAddr takes wrData. Register i occupies activeBus bits [32i+31:32i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| syncClkDisable | input | 1 | Holds the exported synchronization clock low |
| updateStrobe | input | 1 | Asynchronous commit request; its rising edge counts |
| profileIn | input | 2 | Asynchronous profile select |
| keyIn | input | 1 | Asynchronous keying pin |
| wrEn | input | 1 | Buffer write enable |
| wrAddr | input | 2 | Buffer register index |
| wrData | input | 32 | Buffer write value |
| dataIn | input | 14 | Data path input sample |
| syncClkOut | output | 1 | Divide-by-four synchronization clock |
| profileSync | output | 2 | Profile select after synchronization |
| keySync | output | 1 | Keying pin after synchronization |
| activeBus | output | 128 | All active registers, packed |
| dataOut | output | 14 | Scaled or passed-through sample |

## Verification
The bench builds the block with its defaults: a divide ratio of four, four 32-bit registers, and 14-bit data and scale. Because the divider has four phases, the bench can raise the strobe or change a pin in each phase and see the single sampling edge. Because the registers are 32 bits wide, the keying bits 25 and 24 are reachable, so all four bit pairs can be tried. The 14-bit scale allows a zero gain and a full-scale gain of 16383 against the largest data word.

// File: rtl/sync_update_pkg.sv
package sync_update_pkg;

  // Strobes from the control section to the datapath
  typedef struct packed {
    logic sampleTick;  // cycle ending in a synchronization-clock rising edge
    logic commit;      // single-cycle buffer-to-active transfer
  } strobe_t;

endpackage

// File: rtl/sync_update_ctrl.sv
module sync_update_ctrl
  import sync_update_pkg::*;
#(
  parameter int SYNC_DIV = 4,
  localparam int CNT_W = (SYNC_DIV > 1) ? $clog2(SYNC_DIV) : 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    syncClkDisable,
  input  logic    updateStrobe,
  output logic    syncClkOut,
  output strobe_t strb
);

  logic [CNT_W-1:0] divCnt;
  logic sampleTick;
  logic tickDly;
  logic updSync;
  logic updPrev;

  assign sampleTick = (divCnt == CNT_W'(SYNC_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      tickDly <= 1'b0;
      // both start high: a strobe high at reset is not an edge
      updSync <= 1'b1;
      updPrev <= 1'b1;
    end else begin
      divCnt  <= sampleTick ? '0 : divCnt + 1'b1;
      tickDly <= sampleTick;
      if (sampleTick) begin
        updSync <= updateStrobe;
        updPrev <= updSync;
      end
    end
  end

  assign syncClkOut      = !syncClkDisable && (divCnt < CNT_W'(SYNC_DIV / 2));
  assign strb.sampleTick = sampleTick;
  assign strb.commit     = tickDly && updSync && !updPrev;

  // R3: a commit only follows a synchronization-clock rising edge
  assert_commit_on_edge_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> $past(sampleTick));

  // R4: the transfer pulse never lasts two cycles
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> !strb.commit);

  // R1: the exported clock rises only right after a sampling tick
  assert_rise_after_tick_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!syncClkDisable && $past(!syncClkDisable) && $rose(syncClkOut)) |-> $past(sampleTick));

endmodule

// File: rtl/sync_update_dpath.sv
module sync_update_dpath
  import sync_update_pkg::*;
#(
  parameter int NUM_REGS    = 4,
  parameter int REG_W       = 32,
  parameter int DATA_W      = 14,
  parameter int SCALE_W     = 14,
  parameter int PROF_W      = 2,
  parameter int CTRL_ADDR   = 0,
  parameter int SCALE_ADDR  = 1,
  parameter int KEY_EN_BIT  = 25,
  parameter int KEY_SEL_BIT = 24,
  localparam int ADDR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int BUS_W  = NUM_REGS * REG_W,
  localparam int PROD_W = DATA_W + SCALE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic [PROF_W-1:0] profileIn,
  input  logic              keyIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [PROF_W-1:0] profileSync,
  output logic              keySync,
  output logic [BUS_W-1:0]  activeBus,
  output logic [DATA_W-1:0] dataOut
);

  logic [REG_W-1:0] shadowReg [NUM_REGS];
  logic [REG_W-1:0] activeReg [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : gRegs
    // buffer registers: not reset, only written by the port
    always_ff @(posedge clk) begin
      if (wrEn && wrAddr == ADDR_W'(i)) shadowReg[i] <= wrData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            activeReg[i] <= '0;
      else if (strb.commit) activeReg[i] <= shadowReg[i];
    end

    assign activeBus[i*REG_W +: REG_W] = activeReg[i];

    // R5: each active register receives its buffer at the commit edge
    assert_copy_R5: assert property (@(posedge clk) disable iff (!rstN)
      strb.commit |=> activeReg[i] == $past(shadowReg[i]));

    // R7: without a commit the active register holds
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
      !strb.commit |=> $stable(activeReg[i]));
  end

  // pins sampled on the synchronization clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      profileSync <= '0;
      keySync     <= 1'b0;
    end else if (strb.sampleTick) begin
      profileSync <= profileIn;
      keySync     <= keyIn;
    end
  end

  // scaling stage
  logic              keyMode;
  logic [SCALE_W-1:0] scaleVal;
  logic [PROD_W-1:0]  product;
  logic [DATA_W-1:0]  scaled;

  assign keyMode  = activeReg[CTRL_ADDR][KEY_EN_BIT] && !activeReg[CTRL_ADDR][KEY_SEL_BIT];
  assign scaleVal = activeReg[SCALE_ADDR][SCALE_W-1:0];
  assign product  = PROD_W'(dataIn) * PROD_W'(scaleVal);
  assign scaled   = DATA_W'(product >> SCALE_W);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataOut <= '0;
    else       dataOut <= keyMode ? scaled : dataIn;
  end

  // R11: outside keying mode the sample passes unchanged
  assert_unity_R11: assert property (@(posedge clk) disable iff (!rstN)
    !keyMode |=> dataOut == $past(dataIn));

  // R9: synchronized pins only move after a sampling tick
  assert_pins_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.sampleTick |=> ($stable(profileSync) && $stable(keySync)));

endmodule

// File: rtl/sync_update_core.sv
module sync_update_core
  import sync_update_pkg::*;
#(
  parameter int SYNC_DIV = 4,
  parameter int NUM_REGS = 4,
  parameter int REG_W    = 32,
  parameter int DATA_W   = 14,
  parameter int SCALE_W  = 14,
  parameter int PROF_W   = 2,
  localparam int ADDR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int BUS_W  = NUM_REGS * REG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncClkDisable,
  input  logic              updateStrobe,
  input  logic [PROF_W-1:0] profileIn,
  input  logic              keyIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic [DATA_W-1:0] dataIn,
  output logic              syncClkOut,
  output logic [PROF_W-1:0] profileSync,
  output logic              keySync,
  output logic [BUS_W-1:0]  activeBus,
  output logic [DATA_W-1:0] dataOut
);

  strobe_t strb;

  sync_update_ctrl #(.SYNC_DIV(SYNC_DIV)) uCtrl (
    .clk            (clk),
    .rstN           (rstN),
    .syncClkDisable (syncClkDisable),
    .updateStrobe   (updateStrobe),
    .syncClkOut     (syncClkOut),
    .strb           (strb)
  );

  sync_update_dpath #(
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W),
    .DATA_W   (DATA_W),
    .SCALE_W  (SCALE_W),
    .PROF_W   (PROF_W)
  ) uDpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrEn        (wrEn),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .profileIn   (profileIn),
    .keyIn       (keyIn),
    .dataIn      (dataIn),
    .profileSync (profileSync),
    .keySync     (keySync),
    .activeBus   (activeBus),
    .dataOut     (dataOut)
  );

endmodule

// File: tb/sync_update_core_test.sv
`timescale 1ns/1ps
module sync_update_core_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        syncClkDisable = 1'b0;
  logic        updateStrobe = 1'b0;
  logic [1:0]  profileIn = '0;
  logic        keyIn = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [13:0] dataIn = '0;
  logic        syncClkOut;
  logic [1:0]  profileSync;
  logic        keySync;
  logic [127:0] activeBus;
  logic [13:0] dataOut;

  int tests = 0;
  int fails = 0;
  int phase = 0;
  logic [31:0] shadowM [4];
  logic [31:0] activeM [4];

  always #4 clk = ~clk;

  sync_update_core uut (
    .clk(clk), .rstN(rstN), .syncClkDisable(syncClkDisable),
    .updateStrobe(updateStrobe), .profileIn(profileIn), .keyIn(keyIn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .dataIn(dataIn),
    .syncClkOut(syncClkOut), .profileSync(profileSync), .keySync(keySync),
    .activeBus(activeBus), .dataOut(dataOut)
  );

  // phase tracker from R1
  always @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= 0;
    else       phase <= (phase + 1) % 4;
  end

  function automatic logic [127:0] packActive();
    logic [127:0] v;
    for (int i = 0; i < 4; i++) v[i*32 +: 32] = activeM[i];
    return v;
  endfunction

  function automatic logic [13:0] expOut(input logic [13:0] d);
    logic [27:0] p;
    if (activeM[0][25] && !activeM[0][24]) begin
      p = 28'(d) * 28'(activeM[1][13:0]);
      return p[27:14];
    end
    return d;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    shadowM[a] = d;
  endtask

  // raise the strobe, check commit timing (R3, R5), hold, then drop
  task automatic doUpdate(input int hold);
    updateStrobe = 1'b1;
    while (phase != 3) @(negedge clk);
    @(negedge clk);
    chk("R3 unchanged in phase 0", activeBus, packActive());
    @(negedge clk);
    for (int i = 0; i < 4; i++) activeM[i] = shadowM[i];
    chk("R5 all registers committed", activeBus, packActive());
    repeat (hold) @(negedge clk);
    updateStrobe = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic checkData(input string req, input logic [13:0] d);
    dataIn = d;
    @(negedge clk);
    chk(req, 128'(dataOut), 128'(expOut(d)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 4; i++) begin shadowM[i] = '0; activeM[i] = '0; end

    // reset state (R8, R1)
    repeat (3) @(negedge clk);
    chk("R8 active zero in reset", activeBus, 128'd0);
    chk("R1 high in phase 0 under reset", 128'(syncClkOut), 128'd1);
    rstN = 1'b1;

    // R1 waveform
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk("R1 sync clock level", 128'(syncClkOut), 128'(phase < 2));
    end

    // R2 gating
    syncClkDisable = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("R2 gated low", 128'(syncClkOut), 128'd0);
    end
    syncClkDisable = 1'b0;
    @(negedge clk);
    chk("R2 waveform restored", 128'(syncClkOut), 128'(phase < 2));

    // R12 writes, R7 no effect without update
    for (int i = 0; i < 4; i++) wr(2'(i), $urandom());
    repeat (6) @(negedge clk);
    chk("R7 writes alone leave active", activeBus, 128'd0);

    // R8 strobe high across reset
    updateStrobe = 1'b1;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (16) @(negedge clk);
    chk("R8 high strobe at reset no commit", activeBus, 128'd0);
    updateStrobe = 1'b0;
    repeat (8) @(negedge clk);
    doUpdate(0);
    chk("R12 register map on bus", activeBus, packActive());

    // R4 held strobe: writes during the hold must not commit
    updateStrobe = 1'b1;
    while (phase != 3) @(negedge clk);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 4; i++) activeM[i] = shadowM[i];
    chk("R3 commit after edge", activeBus, packActive());
    for (int i = 0; i < 4; i++) wr(2'(i), $urandom());
    repeat (20) @(negedge clk);
    chk("R4 no repeat while held high", activeBus, packActive());
    updateStrobe = 1'b0;
    repeat (8) @(negedge clk);
    chk("R4 still no commit after drop", activeBus, packActive());
    doUpdate(3);

    // R6 last write wins
    wr(2'd2, 32'h1111_1111);
    wr(2'd2, 32'h2222_2222);
    wr(2'd3, 32'hDEAD_BEEF);
    chk("R7 pending writes invisible", activeBus, packActive());
    doUpdate(1);
    chk("R6 last write committed", 128'(activeBus[95:64]), 128'h2222_2222);

    // directed keying corners (R10)
    wr(2'd0, 32'h0200_0000);
    wr(2'd1, 32'h0000_3FFF);
    doUpdate(0);
    checkData("R10 full scale max data", 14'h3FFF);
    checkData("R10 full scale mid data", 14'h2000);
    wr(2'd1, 32'h0000_0000);
    doUpdate(0);
    checkData("R10 zero scale", 14'h3FFF);
    wr(2'd0, 32'h0300_0000);
    doUpdate(0);
    checkData("R11 bits 11 unity", 14'h1234);

    // random modes and data (R10, R11)
    for (int it = 0; it < 16; it++) begin
      logic [31:0] c;
      c = $urandom();
      c[25:24] = 2'(it % 4);
      wr(2'd0, c);
      wr(2'd1, $urandom());
      if (it % 3 == 0) wr(2'(2 + it % 2), $urandom());
      doUpdate(it % 3);
      for (int k = 0; k < 6; k++) begin
        if (activeM[0][25] && !activeM[0][24]) checkData("R10 keyed scaling", 14'($urandom()));
        else checkData("R11 unity pass", 14'($urandom()));
      end
    end

    // R9 pin sampling
    for (int it = 0; it < 6; it++) begin
      logic [1:0] oldP, newP;
      logic oldK, newK;
      while (phase != 1) @(negedge clk);
      oldP = profileSync; oldK = keySync;
      newP = 2'($urandom()); newK = 1'($urandom());
      profileIn = newP; keyIn = newK;
      @(negedge clk);
      chk("R9 profile holds phase 2", 128'(profileSync), 128'(oldP));
      @(negedge clk);
      chk("R9 key holds phase 3", 128'(keySync), 128'(oldK));
      @(negedge clk);
      chk("R9 profile sampled at edge", 128'(profileSync), 128'(newP));
      chk("R9 key sampled at edge", 128'(keySync), 128'(newK));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule